// File: doc/BRIEF.md
# Two-Wire Identification Memory Slave

This block is a two-wire bus slave that behaves like a small identification memory: a 256-byte array that a host can write and read over SCL/SDA. SCL and SDA are oversampled by the system clock and resynchronised. The block finds start and stop conditions in the sampled lines and decodes a device-select byte. It acknowledges when that byte carries the fixed device-type code and the three strap pins, then runs a write or a read transfer.

A write sets an internal word pointer from its first data byte. Each following byte is stored at the pointer, and the pointer then advances. A read returns bytes from the pointer onward for as long as the host acknowledges each one. After any write that stored data, the slave waits a programmable number of system clocks before it answers its address again. The slave drives SDA only low, through a drive-low enable output. An open-drain pad, or the bus model in the bench, resolves the line.

Top module: `twi_id_store`

## Requirements
- R1: Out of reset, the drive-low enable is 0 and the slave ignores the bus until a start condition.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bits clocked without a preceding start are never acknowledged.
- R3: The select byte is received MSB first. Bits 7..4 must equal 4'b1010 and bits 3..1 must equal the strap inputs. Bit 0 selects read (1) or write (0). The slave acknowledges a match by driving SDA low for the ninth clock. On a mismatch it drives nothing and waits for the next start.
- R4: In a write, the first byte after the select byte loads the word pointer. Each later byte is stored at the pointer, the pointer then increments, and each byte is acknowledged.
- R5: In a read, the slave sends the byte at the pointer MSB first and then increments the pointer. It sends the next byte whenever the host pulls SDA low on the ninth clock.
- R6: When the host leaves the ninth read bit high, the slave releases SDA and sends nothing more until a stop or a start.
- R7: The word pointer wraps from 255 to 0, for both writes and reads.
- R8: After the stop of a write that stored at least one byte, the slave acknowledges no select byte for BUSY_CYCLES system clocks.
- R9: A start in the middle of a transfer abandons any partial byte, stores nothing from it, and restarts select-byte decoding. The word pointer is kept, so a write of the pointer followed by a repeated start and a read select gives a random read.
- R10: The slave changes its drive on SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Resolved bus data line as seen at the pad |
| strap_i | input | 3 | Strapped address bits matched against select bits 3..1 |
| sda_low_o | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The assertions assume a well-behaved host. It changes SDA only while SCL is low, except when it makes a start or a stop. It never makes a start or a stop while the slave holds SDA low. It holds each SCL phase for several system clocks, so that the resynchronised edges arrive before the next phase. The bench host drives each SCL quarter-period for eight system clocks and moves SDA only in the middle of the low phase. It releases SDA during every ninth clock and every read bit, so the slave's drive is visible on the resolved line.

// File: rtl/twi_id_pkg.sv
package twi_id_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL,
        ST_SACK,
        ST_WADDR,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_WSTOP
    } twi_state_e;

    localparam int BYTE_W = 8;
    localparam int BITS_W = 4;

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_sr_q, sda_sr_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr_q   <= '1;
            sda_sr_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sr_q   <= {scl_sr_q[STAGES-2:0], scl_i};
            sda_sr_q   <= {sda_sr_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_sr_q[STAGES-1];
            sda_prev_q <= sda_sr_q[STAGES-1];
        end
    end

    assign scl_lvl   = scl_sr_q[STAGES-1];
    assign sda_lvl   = sda_sr_q[STAGES-1];
    assign scl_rise  = scl_lvl & ~scl_prev_q;
    assign scl_fall  = ~scl_lvl & scl_prev_q;
    // both line samples high on SCL around the SDA edge
    assign start_det = scl_lvl & scl_prev_q & sda_prev_q & ~sda_lvl;
    assign stop_det  = scl_lvl & scl_prev_q & ~sda_prev_q & sda_lvl;

endmodule

// File: rtl/twi_id_array.sv
module twi_id_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[wa] <= wd;
        end
    end

    assign rd = mem_q[ra];

endmodule

// File: rtl/twi_id_core.sv
module twi_id_core
    import twi_id_pkg::*;
#(
    parameter int          AW          = 8,
    parameter int          BUSY_CYCLES = 200,
    parameter logic [3:0]  DEV_CODE    = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [2:0]        strap,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              mem_we,
    output logic [AW-1:0]     mem_wa,
    output logic [BYTE_W-1:0] mem_wd,
    output logic [AW-1:0]     mem_ra,
    output logic              sda_low
);
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    typedef struct packed {
        twi_state_e        st;
        logic [BITS_W-1:0] cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic [AW-1:0]     ptr;
        logic              rw;
        logic              acked;
        logic              wr_pend;
        logic [BW-1:0]     busy;
        logic              drv;
    } core_t;

    core_t q, d;
    logic  sel_match;

    assign sel_match = (q.sh[7:4] == DEV_CODE) && (q.sh[3:1] == strap) && (q.busy == '0);

    always_comb begin
        d      = q;
        mem_we = 1'b0;
        mem_wa = q.ptr;
        mem_wd = q.sh;
        if (q.busy != '0) d.busy = q.busy - 1'b1;

        if (stop_det) begin
            d.st  = ST_IDLE;
            d.drv = 1'b0;
            if (q.wr_pend) begin
                d.busy    = BW'(BUSY_CYCLES);
                d.wr_pend = 1'b0;
            end
        end else if (start_det) begin
            d.st  = ST_SEL;
            d.cnt = '0;
            d.drv = 1'b0;
        end else begin
            case (q.st)
                ST_SEL, ST_WADDR, ST_WDATA: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_lvl};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BITS_W'(8)) begin
                        d.cnt = '0;
                        if (q.st == ST_SEL) begin
                            if (sel_match) begin
                                d.st  = ST_SACK;
                                d.drv = 1'b1;
                                d.rw  = q.sh[0];
                            end else begin
                                d.st  = ST_IDLE;
                            end
                        end else if (q.st == ST_WADDR) begin
                            d.ptr = q.sh[AW-1:0];
                            d.st  = ST_WACK;
                            d.drv = 1'b1;
                        end else begin
                            mem_we    = 1'b1;
                            d.ptr     = q.ptr + 1'b1;
                            d.wr_pend = 1'b1;
                            d.st      = ST_WACK;
                            d.drv     = 1'b1;
                        end
                    end
                end
                ST_SACK: begin
                    if (scl_fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st  = ST_RDATA;
                            d.tx  = rd_data;
                            d.ptr = q.ptr + 1'b1;
                            d.drv = ~rd_data[7];
                        end else begin
                            d.st  = ST_WADDR;
                            d.drv = 1'b0;
                        end
                    end
                end
                ST_WACK: begin
                    if (scl_fall) begin
                        d.st  = ST_WDATA;
                        d.drv = 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == BITS_W'(8)) begin
                            d.st  = ST_RACK;
                            d.drv = 1'b0;
                        end else begin
                            d.tx  = {q.tx[6:0], 1'b0};
                            d.drv = ~q.tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.acked = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.acked) begin
                            d.st  = ST_RDATA;
                            d.cnt = '0;
                            d.tx  = rd_data;
                            d.ptr = q.ptr + 1'b1;
                            d.drv = ~rd_data[7];
                        end else begin
                            d.st  = ST_WSTOP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: '0, sh: '0, tx: '0, ptr: '0, rw: 1'b0,
                   acked: 1'b0, wr_pend: 1'b0, busy: '0, drv: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mem_ra  = q.ptr;
    assign sda_low = q.drv;

    a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.drv);
    a_r3_ack_only_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SACK) |-> (q.sh[7:1] == {DEV_CODE, strap}));
    a_r6_nack_stays_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_WSTOP) |-> !q.drv);
    a_r8_no_select_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy != '0) |-> (q.st != ST_SACK));
    a_r10_drive_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.drv != $past(q.drv)) |-> !scl_lvl);

endmodule

// File: rtl/twi_id_store.sv
module twi_id_store
    import twi_id_pkg::*;
#(
    parameter int         AW          = 8,
    parameter int         BUSY_CYCLES = 200,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_low_o
);
    logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic              mem_we;
    logic [AW-1:0]     mem_wa, mem_ra;
    logic [BYTE_W-1:0] mem_wd, mem_rd;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    twi_id_core #(.AW(AW), .BUSY_CYCLES(BUSY_CYCLES), .DEV_CODE(DEV_CODE)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .strap     (strap_i),
        .rd_data   (mem_rd),
        .mem_we    (mem_we),
        .mem_wa    (mem_wa),
        .mem_wd    (mem_wd),
        .mem_ra    (mem_ra),
        .sda_low   (sda_low_o)
    );

    twi_id_array #(.AW(AW), .DW(BYTE_W)) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .wa    (mem_wa),
        .wd    (mem_wd),
        .ra    (mem_ra),
        .rd    (mem_rd)
    );

endmodule

// File: tb/twi_id_store_bench.sv
`timescale 1ns/1ps
module twi_id_store_bench;
    localparam time PERIOD = 10ns;
    localparam time Q      = 8 * PERIOD;
    localparam int  BUSY   = 400;

    typedef struct {
        string      req;
        logic [7:0] val;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_low;
    logic       sda_line;

    int tests = 0;
    int fails = 0;
    int r10_viol = 0;
    item_t exp_q[$];
    logic [7:0] obs_q[$];

    assign sda_line = sda_m & ~sda_low;

    always #(PERIOD/2) clk = ~clk;

    twi_id_store #(.BUSY_CYCLES(BUSY)) u_twi_id_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_line),
        .strap_i   (strap),
        .sda_low_o (sda_low)
    );

    // scoreboard monitor: compares observed items against expected ones in order
    initial begin
        forever begin
            @(negedge clk);
            while (obs_q.size() > 0 && exp_q.size() > 0) begin
                item_t e;
                logic [7:0] o;
                e = exp_q.pop_front();
                o = obs_q.pop_front();
                tests++;
                if (o !== e.val) begin
                    fails++;
                    $display("FAIL %s: actual 0x%02h expected 0x%02h", e.req, o, e.val);
                end
            end
        end
    end

    // R10 watcher: drive may only change while SCL is low
    logic drv_prev = 1'b0;
    always @(posedge clk) begin
        if (rst_n && sda_low !== drv_prev && scl) r10_viol++;
        drv_prev <= sda_low;
    end

    task automatic bus_start();
        scl = 1'b0; #Q; sda_m = 1'b1; #Q; scl = 1'b1; #Q; sda_m = 1'b0; #Q;
    endtask

    task automatic bus_stop();
        scl = 1'b0; #Q; sda_m = 1'b0; #Q; scl = 1'b1; #Q; sda_m = 1'b1; #(2*Q);
    endtask

    task automatic bit_out(input logic b);
        scl = 1'b0; #Q; sda_m = b; #Q; scl = 1'b1; #(2*Q);
    endtask

    // sends a byte and records the ninth-clock line level (0 = acknowledged)
    task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string req);
        logic seen;
        exp_q.push_back('{req, {7'd0, ~exp_ack}});
        for (int i = 7; i >= 0; i--) bit_out(v[i]);
        scl = 1'b0; #Q; sda_m = 1'b1; #Q; scl = 1'b1; #Q;
        seen = sda_line;
        #Q;
        obs_q.push_back({7'd0, seen});
    endtask

    task automatic recv_byte(input logic [7:0] expv, input logic host_ack, input string req);
        logic [7:0] v = '0;
        exp_q.push_back('{req, expv});
        for (int i = 0; i < 8; i++) begin
            scl = 1'b0; #Q; sda_m = 1'b1; #Q; scl = 1'b1; #Q;
            v = {v[6:0], sda_line};
            #Q;
        end
        scl = 1'b0; #Q; sda_m = ~host_ack; #Q; scl = 1'b1; #(2*Q);
        obs_q.push_back(v);
    endtask

    initial begin
        #(PERIOD * 150000);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        tests++;
        if (sda_low !== 1'b0) begin
            fails++;
            $display("FAIL R1: actual %b expected 0", sda_low);
        end
        rst_n = 1'b1;
        repeat (4) @(posedge clk);

        // R2: a matching select byte with no start before it gets no acknowledge
        send_byte(8'hAA, 1'b0, "R2 no start");
        bus_stop();

        // R3: wrong strap bits
        bus_start();
        send_byte(8'hA2, 1'b0, "R3 strap mismatch");
        bus_stop();
        // R3: wrong device code
        bus_start();
        send_byte(8'hEA, 1'b0, "R3 code mismatch");
        bus_stop();

        // R3 R4: pointer 0x10, three data bytes
        bus_start();
        send_byte(8'hAA, 1'b1, "R3 select write");
        send_byte(8'h10, 1'b1, "R4 pointer byte");
        send_byte(8'h5A, 1'b1, "R4 data0");
        send_byte(8'hC3, 1'b1, "R4 data1");
        send_byte(8'h01, 1'b1, "R4 data2");
        bus_stop();

        // R8: address ignored during the write cycle
        bus_start();
        send_byte(8'hAA, 1'b0, "R8 busy no ack");
        bus_stop();
        repeat (BUSY + 100) @(posedge clk);

        // R9 R5 R6: random read with repeated start, host NACKs the third byte
        bus_start();
        send_byte(8'hAA, 1'b1, "R9 select write");
        send_byte(8'h10, 1'b1, "R9 pointer byte");
        bus_start();
        send_byte(8'hAB, 1'b1, "R9 select read after restart");
        recv_byte(8'h5A, 1'b1, "R5 read0");
        recv_byte(8'hC3, 1'b1, "R5 read1");
        recv_byte(8'h01, 1'b0, "R5 read2");
        recv_byte(8'hFF, 1'b0, "R6 released after nack");
        bus_stop();

        // R7: write across the top of the array
        bus_start();
        send_byte(8'hAA, 1'b1, "R7 select write");
        send_byte(8'hFE, 1'b1, "R7 pointer byte");
        send_byte(8'h11, 1'b1, "R7 data fe");
        send_byte(8'h22, 1'b1, "R7 data ff");
        send_byte(8'h33, 1'b1, "R7 data 00");
        bus_stop();
        repeat (BUSY + 100) @(posedge clk);

        bus_start();
        send_byte(8'hAA, 1'b1, "R7 select write");
        send_byte(8'hFF, 1'b1, "R7 pointer ff");
        bus_start();
        send_byte(8'hAB, 1'b1, "R7 select read");
        recv_byte(8'h22, 1'b1, "R7 read ff");
        recv_byte(8'h33, 1'b0, "R7 read wrapped 00");
        bus_stop();

        // R5: current-address read continues at 0x01 (reset contents 0)
        bus_start();
        send_byte(8'hAB, 1'b1, "R5 select current read");
        recv_byte(8'h00, 1'b0, "R5 current address");
        bus_stop();

        // R9: start inside a data byte discards it
        bus_start();
        send_byte(8'hAA, 1'b1, "R9 select write");
        send_byte(8'h11, 1'b1, "R9 pointer 11");
        bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
        bus_start();
        send_byte(8'hAB, 1'b1, "R9 select read mid-byte");
        recv_byte(8'hC3, 1'b0, "R9 partial byte not stored");
        bus_stop();

        // R9: no write happened, so no busy period follows
        bus_start();
        send_byte(8'hAB, 1'b1, "R9 no busy after aborted write");
        recv_byte(8'h01, 1'b0, "R9 pointer after read");
        bus_stop();

        repeat (20) @(posedge clk);
        tests++;
        if (r10_viol != 0) begin
            fails++;
            $display("FAIL R10: actual %0d changes with SCL high expected 0", r10_viol);
        end
        tests++;
        if (exp_q.size() != 0 || obs_q.size() != 0) begin
            fails++;
            $display("FAIL scoreboard drain: actual %0d/%0d left expected 0/0",
                     exp_q.size(), obs_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule